// File: doc/BRIEF.md
# Class-Keyed Instruction Fetch Lookup

This unit sits in front of a direct-mapped instruction cache and chooses the cache set for each fetch. It has two lookup modes. In PC mode the set comes from the program counter with its byte-in-line bits cleared, and the PC steps by one instruction word after each issued fetch. When decode signals a dispatch instruction, the unit switches to keyed mode. In keyed mode the set comes from a 64-bit key made of a 32-bit site value and the 32-bit class pointer of the receiver. The site value is either the current PC or an explicit value supplied with the instruction, so several call sites can share one entry.

In keyed mode, one cache line holds one dispatch entry. The words of that line are issued in order while the architectural PC stays frozen. Any branch or call redirect returns the unit to PC mode at the new target. A fetch after the last word of a keyed line raises an error pulse and falls back to PC mode. On a miss, the unit raises a refill request that carries the key and stalls. When the refill is accepted it writes the line and retries the lookup.

Top module: `dispatch_fetch_unit`

## Requirements
- R1: After reset every line is invalid, the unit is in PC mode and pc_out is RESET_PC (0). With fetch_req low, fetch_valid, refill_req and overrun_err are all 0. The first fetch misses, with refill_keyed = 0.
- R2: In PC mode the key is {32'h0, pc with bits [3:0] cleared}. The set index is bits [9:4] of (key[63:32] XOR key[31:0]). The word issued is word pc[3:2] of the line, and word w sits at line bits [32w+31:32w].
- R3: A PC-mode fetch that hits gives fetch_valid = 1 in the same cycle with the selected word. pc_out then advances by 4.
- R4: A dispatch with disp_use_site = 0 enters keyed mode with key {pc_out, disp_class} and word offset 0. refill_keyed reads 1 in that mode.
- R5: A dispatch with disp_use_site = 1 uses key {disp_site, disp_class}. Two dispatches from different PCs that supply the same site and class share one line, and the second one hits at once with no refill.
- R6: In keyed mode, successive fetches that hit issue words 0, 1, 2 and 3 of the line in order, each in the cycle it is requested. pc_out does not change.
- R7: redirect_valid takes priority over dispatch and fetch in the same cycle: no word is issued and no refill is requested. The next cycle is in PC mode with pc_out = redirect_pc, including when the unit was part way through a keyed line.
- R8: A keyed-mode fetch after all 4 words were issued, with no redirect in between, raises overrun_err in that cycle and issues no word. The next cycle is in PC mode at the unchanged pc_out.
- R9: A miss holds refill_req = 1 with fetch_valid = 0 until refill_valid is seen. refill_key and refill_keyed carry the key and mode. The accepted refill_line is written, and the retried lookup in the next cycle hits.
- R10: Each tag holds the mode flag as well as the key. A keyed key equal in value to the key of a stored PC-mode line still misses.
- R11: The cache is direct-mapped. A refill to a set evicts the line held there before, so PC 0x400 and PC 0x000 (both set 0) evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Fetch stage requests the next instruction |
| fetch_valid | output | 1 | An instruction word is issued this cycle |
| fetch_instr | output | 32 | Issued instruction word |
| pc_out | output | 32 | Architectural PC |
| disp_issue | input | 1 | Decode issued a dispatch instruction |
| disp_use_site | input | 1 | Use disp_site instead of the PC in the key |
| disp_site | input | 32 | Explicit site value |
| disp_class | input | 32 | Receiver class pointer |
| redirect_valid | input | 1 | Branch or call redirect |
| redirect_pc | input | 32 | Redirect target |
| refill_req | output | 1 | Miss: line refill requested |
| refill_key | output | 64 | Key of the missing line |
| refill_keyed | output | 1 | Missing line belongs to keyed mode |
| refill_valid | input | 1 | Refill data present |
| refill_line | input | 128 | Refill line data, word 0 in the low bits |
| overrun_err | output | 1 | Keyed fetch ran past the end of the line |

## Verification
The bench uses the default geometry: 64 lines of 16 bytes, which gives four words per line and a six-bit set index taken from bits [9:4] of the folded key. With these values, hand-picked addresses such as 0x000 and 0x400 collide in one set. A keyed key can equal a PC-mode key bit for bit, which exercises the mode flag in the tag. The line end is reached after four keyed fetches, so an overrun comes within a few cycles of a dispatch.

// File: rtl/dfu_pkg.sv
// Shared types for the class-keyed fetch lookup unit.
package dfu_pkg;
    // Lookup mode: PC-indexed or class-keyed dispatch.
    typedef enum logic {
        MODE_PC    = 1'b0,
        MODE_KEYED = 1'b1
    } fetch_mode_e;
endpackage

// File: rtl/dfu_key_hash.sv
// Builds the lookup key for the current mode and folds it into a set index.
// Assumes LINES and LINE_BYTES are powers of two.
module dfu_key_hash #(
    parameter int AW         = 32,
    parameter int LINES      = 64,
    parameter int LINE_BYTES = 16
) (
    input  dfu_pkg::fetch_mode_e   mode,
    input  logic [AW-1:0]          pc,
    input  logic [AW-1:0]          site,
    input  logic [AW-1:0]          cls,
    output logic [2*AW-1:0]        key,
    output logic [$clog2(LINES)-1:0] index
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam logic [AW-1:0] LINE_MASK = ~AW'(LINE_BYTES - 1);

    logic [AW-1:0] fold;

    // Select the key source and fold the two halves by XOR.
    always_comb begin
        if (mode == dfu_pkg::MODE_KEYED)
            key = {site, cls};
        else
            key = {AW'(0), pc & LINE_MASK};
        fold  = key[2*AW-1:AW] ^ key[AW-1:0];
        index = IDX_W'(fold >> OFF_W);
    end
endmodule

// File: rtl/dfu_line_store.sv
// Direct-mapped line storage: valid bits, tag (key plus mode flag) and data.
// One read port (combinational) and one refill write port.
module dfu_line_store #(
    parameter int LINES  = 64,
    parameter int KW     = 64,
    parameter int LINE_W = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    input  logic [KW-1:0]            rd_key,
    input  logic                     rd_mode,
    output logic                     hit,
    output logic [LINE_W-1:0]        rd_line,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [KW-1:0]            wr_key,
    input  logic                     wr_mode,
    input  logic [LINE_W-1:0]        wr_line
);
    logic [LINES-1:0] valid_q;
    logic [KW-1:0]    tag_key_q  [LINES];
    logic             tag_mode_q [LINES];
    logic [LINE_W-1:0] data_q    [LINES];
    logic [LINES-1:0] match;

    // Valid bits: cleared by reset, set by a refill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= 1'b1;
    end

    // Tag and data arrays: written on refill, not reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_key_q[wr_idx]  <= wr_key;
            tag_mode_q[wr_idx] <= wr_mode;
            data_q[wr_idx]     <= wr_line;
        end
    end

    // Per-line tag compare against the current lookup key and mode.
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_mode_q[g] == rd_mode) && (tag_key_q[g] == rd_key);
    end

    assign hit     = match[rd_idx];
    assign rd_line = data_q[rd_idx];
endmodule

// File: rtl/dfu_seq_ctrl.sv
// Mode, PC, dispatch key and keyed word-offset sequencing.
// Priority: redirect, then dispatch, then fetch. Assumes WORDS is a power of two.
module dfu_seq_ctrl #(
    parameter int AW               = 32,
    parameter int WORDS            = 4,
    parameter int WORD_BYTES       = 4,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fetch_req,
    input  logic                  redirect_valid,
    input  logic [AW-1:0]         redirect_pc,
    input  logic                  disp_issue,
    input  logic                  disp_use_site,
    input  logic [AW-1:0]         disp_site,
    input  logic [AW-1:0]         disp_class,
    input  logic                  lookup_hit,
    output dfu_pkg::fetch_mode_e  mode,
    output logic [AW-1:0]         pc,
    output logic [AW-1:0]         site,
    output logic [AW-1:0]         cls,
    output logic [$clog2(WORDS+1)-1:0] offset,
    output logic                  issue,
    output logic                  overrun,
    output logic                  miss
);
    import dfu_pkg::*;
    localparam int OW = $clog2(WORDS + 1);

    fetch_mode_e   mode_q;
    logic [AW-1:0] pc_q, site_q, cls_q;
    logic [OW-1:0] off_q;
    logic          blocked;

    // Per-cycle decision: which of issue, overrun or miss applies.
    always_comb begin
        blocked = redirect_valid || disp_issue;
        overrun = fetch_req && !blocked && (mode_q == MODE_KEYED) && (off_q == OW'(WORDS));
        issue   = fetch_req && !blocked && !overrun && lookup_hit;
        miss    = fetch_req && !blocked && !overrun && !lookup_hit;
    end

    // State update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PC;
            pc_q   <= AW'(RESET_PC);
            site_q <= '0;
            cls_q  <= '0;
            off_q  <= '0;
        end else if (redirect_valid) begin
            mode_q <= MODE_PC;
            pc_q   <= redirect_pc;
        end else if (disp_issue) begin
            mode_q <= MODE_KEYED;
            site_q <= disp_use_site ? disp_site : pc_q;
            cls_q  <= disp_class;
            off_q  <= '0;
        end else if (overrun) begin
            mode_q <= MODE_PC;
        end else if (issue) begin
            if (mode_q == MODE_KEYED)
                off_q <= off_q + OW'(1);
            else
                pc_q <= pc_q + AW'(WORD_BYTES);
        end
    end

    assign mode   = mode_q;
    assign pc     = pc_q;
    assign site   = site_q;
    assign cls    = cls_q;
    assign offset = off_q;

    // R6: the architectural PC holds while in keyed mode.
    p_pc_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_KEYED && !redirect_valid) |=> (pc_q == $past(pc_q)));

    // R6: the word offset never passes the line end.
    p_offset_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= OW'(WORDS));

    // R7: a redirect lands in PC mode at its target.
    p_redirect_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (mode_q == MODE_PC && pc_q == $past(redirect_pc)));

    // R4: a dispatch enters keyed mode at word 0.
    p_dispatch_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_issue && !redirect_valid) |=> (mode_q == MODE_KEYED && off_q == '0));

    // R8: an overrun falls back to PC mode.
    p_overrun_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> (mode_q == MODE_PC && pc_q == $past(pc_q)));
endmodule

// File: rtl/dispatch_fetch_unit.sv
// Top level: class-keyed instruction fetch lookup for a direct-mapped cache.
// Assumes a single-cycle tag/data read and that a refill line arrives whole.
module dispatch_fetch_unit #(
    parameter int AW               = 32,
    parameter int LINES            = 64,
    parameter int LINE_BYTES       = 16,
    parameter int WORD_BYTES       = 4,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fetch_req,
    output logic                    fetch_valid,
    output logic [AW-1:0]           fetch_instr,
    output logic [AW-1:0]           pc_out,
    input  logic                    disp_issue,
    input  logic                    disp_use_site,
    input  logic [AW-1:0]           disp_site,
    input  logic [AW-1:0]           disp_class,
    input  logic                    redirect_valid,
    input  logic [AW-1:0]           redirect_pc,
    output logic                    refill_req,
    output logic [2*AW-1:0]         refill_key,
    output logic                    refill_keyed,
    input  logic                    refill_valid,
    input  logic [LINE_BYTES*8-1:0] refill_line,
    output logic                    overrun_err
);
    import dfu_pkg::*;
    localparam int KW     = 2 * AW;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORDS  = LINE_BYTES / WORD_BYTES;
    localparam int IDX_W  = $clog2(LINES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int WB_W   = $clog2(WORD_BYTES);
    localparam int OW     = $clog2(WORDS + 1);

    fetch_mode_e       mode;
    logic [AW-1:0]     pc, site, cls;
    logic [OW-1:0]     offset;
    logic [KW-1:0]     key;
    logic [IDX_W-1:0]  index;
    logic              lookup_hit, issue, overrun, miss;
    logic [LINE_W-1:0] line;
    logic [WSEL_W-1:0] word_sel;

    dfu_seq_ctrl #(.AW(AW), .WORDS(WORDS), .WORD_BYTES(WORD_BYTES), .RESET_PC(RESET_PC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .disp_issue(disp_issue), .disp_use_site(disp_use_site),
        .disp_site(disp_site), .disp_class(disp_class),
        .lookup_hit(lookup_hit), .mode(mode), .pc(pc), .site(site), .cls(cls),
        .offset(offset), .issue(issue), .overrun(overrun), .miss(miss)
    );

    dfu_key_hash #(.AW(AW), .LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_hash (
        .mode(mode), .pc(pc), .site(site), .cls(cls), .key(key), .index(index)
    );

    dfu_line_store #(.LINES(LINES), .KW(KW), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(index), .rd_key(key), .rd_mode(mode == MODE_KEYED),
        .hit(lookup_hit), .rd_line(line),
        .wr_en(miss && refill_valid), .wr_idx(index), .wr_key(key),
        .wr_mode(mode == MODE_KEYED), .wr_line(refill_line)
    );

    // Word select: keyed offset, or the word bits of the PC.
    always_comb begin
        if (mode == MODE_KEYED)
            word_sel = WSEL_W'(offset);
        else
            word_sel = WSEL_W'(pc >> WB_W);
    end

    assign fetch_valid  = issue;
    assign fetch_instr  = line[word_sel*AW +: AW];
    assign pc_out       = pc;
    assign refill_req   = miss;
    assign refill_key   = key;
    assign refill_keyed = (mode == MODE_KEYED);
    assign overrun_err  = overrun;

    // R9: an accepted refill makes the retried lookup hit.
    p_refill_then_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && refill_valid) |=> lookup_hit);

    // R9: a pending miss holds its key until the refill arrives.
    p_miss_key_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_valid) |=> $stable(refill_key));

    // R7: no issue and no refill during a redirect.
    p_redirect_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (!fetch_valid && !refill_req && !overrun_err));
endmodule

// File: tb/sim_dispatch_fetch_unit.sv
module sim_dispatch_fetch_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_req = 0, disp_issue = 0, disp_use_site = 0, redirect_valid = 0, refill_valid = 0;
    logic [31:0] disp_site = 0, disp_class = 0, redirect_pc = 0;
    logic [127:0] refill_line = 0;
    logic fetch_valid, refill_req, refill_keyed, overrun_err;
    logic [31:0] fetch_instr, pc_out;
    logic [63:0] refill_key;

    dispatch_fetch_unit u0 (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_valid(fetch_valid),
        .fetch_instr(fetch_instr), .pc_out(pc_out), .disp_issue(disp_issue),
        .disp_use_site(disp_use_site), .disp_site(disp_site), .disp_class(disp_class),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .refill_req(refill_req), .refill_key(refill_key), .refill_keyed(refill_keyed),
        .refill_valid(refill_valid), .refill_line(refill_line), .overrun_err(overrun_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit auto_ref = 1;

    // Reference model state.
    bit          m_valid [64];
    logic [63:0] m_tag   [64];
    bit          m_tmode [64];
    logic [127:0] m_data [64];
    logic [31:0] m_pc, m_site, m_cls;
    bit          m_keyed;
    int          m_off;

    // Observed outputs of the last cycle.
    logic o_fv, o_rq, o_over, o_keyed;
    logic [63:0] o_key;
    logic [31:0] o_instr;

    function automatic logic [127:0] line_for(logic [63:0] k);
        logic [127:0] l;
        for (int w = 0; w < 4; w++)
            l[w*32 +: 32] = k[31:0] + k[63:32] * 3 + w * 32'h0101_0007 + 32'h5A00_0000;
        return l;
    endfunction

    function automatic logic [63:0] model_key();
        if (m_keyed) return {m_site, m_cls};
        return {32'h0, m_pc & 32'hFFFF_FFF0};
    endfunction

    function automatic int set_of(logic [63:0] k);
        logic [31:0] f;
        f = k[63:32] ^ k[31:0];
        return int'((f >> 4) & 32'h3F);
    endfunction

    task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: inputs already driven after the falling edge.
    task automatic cycle(string tag);
        logic [63:0] k;
        int idx, w;
        bit hit, blocked, over, fv, rq;
        k = model_key();
        idx = set_of(k);
        hit = m_valid[idx] && (m_tmode[idx] == m_keyed) && (m_tag[idx] == k);
        blocked = redirect_valid || disp_issue;
        over = rst_n && fetch_req && !blocked && m_keyed && (m_off == 4);
        fv = rst_n && fetch_req && !blocked && !over && hit;
        rq = rst_n && fetch_req && !blocked && !over && !hit;
        w = m_keyed ? m_off : int'((m_pc >> 2) & 3);
        if (auto_ref) refill_valid = rq;
        refill_line = line_for(k);
        #(CLK_PERIOD/4);
        o_fv = fetch_valid; o_rq = refill_req; o_over = overrun_err;
        o_key = refill_key; o_keyed = refill_keyed; o_instr = fetch_instr;
        if (rst_n) begin
            chk(tag, "fetch_valid", 128'(fetch_valid), 128'(fv));
            chk(tag, "refill_req", 128'(refill_req), 128'(rq));
            chk(tag, "overrun_err", 128'(overrun_err), 128'(over));
            chk(tag, "refill_key", 128'(refill_key), 128'(k));
            chk(tag, "refill_keyed", 128'(refill_keyed), 128'(m_keyed));
            chk(tag, "pc_out", 128'(pc_out), 128'(m_pc));
            if (fv) chk(tag, "fetch_instr", 128'(fetch_instr), 128'(m_data[idx][w*32 +: 32]));
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_valid[i] = 0;
            m_pc = 0; m_keyed = 0; m_off = 0; m_site = 0; m_cls = 0;
        end else if (redirect_valid) begin
            m_pc = redirect_pc; m_keyed = 0;
        end else if (disp_issue) begin
            m_keyed = 1; m_site = disp_use_site ? disp_site : m_pc; m_cls = disp_class; m_off = 0;
        end else if (over) begin
            m_keyed = 0;
        end else if (fv) begin
            if (m_keyed) m_off++; else m_pc += 4;
        end else if (rq && refill_valid) begin
            m_valid[idx] = 1; m_tag[idx] = k; m_tmode[idx] = m_keyed; m_data[idx] = refill_line;
        end
        @(negedge clk);
        fetch_req = 0; disp_issue = 0; redirect_valid = 0; disp_use_site = 0;
        if (auto_ref) refill_valid = 0;
    endtask

    task automatic do_fetch(string tag, int n);
        for (int i = 0; i < n; i++) begin
            fetch_req = 1;
            cycle(tag);
        end
    endtask

    task automatic do_redirect(string tag, logic [31:0] t);
        redirect_valid = 1; redirect_pc = t; fetch_req = 1;
        cycle(tag);
    endtask

    task automatic do_disp(string tag, bit us, logic [31:0] s, logic [31:0] c);
        disp_issue = 1; disp_use_site = us; disp_site = s; disp_class = c; fetch_req = 1;
        cycle(tag);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog timeout");
        finish_run();
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) cycle("R1");
        rst_n = 1;
        cycle("R1");
        chk("R1", "pc_out_reset", 128'(pc_out), 128'h0);
        chk("R1", "idle_valid", 128'(o_fv), 128'h0);
        // First fetch misses; hold the refill off for two cycles.
        auto_ref = 0;
        do_fetch("R1", 1);
        chk("R1", "first_miss", 128'(o_rq), 128'h1);
        chk("R1", "first_miss_keyed", 128'(o_keyed), 128'h0);
        do_fetch("R9", 1);
        chk("R9", "stall_no_valid", 128'(o_fv), 128'h0);
        auto_ref = 1;
        do_fetch("R9", 1);
        do_fetch("R3", 4);
        chk("R3", "pc_after_line", 128'(pc_out), 128'h10);
        do_fetch("R9", 2);
        // Redirect wins over a dispatch and a fetch in the same cycle.
        disp_issue = 1; disp_class = 32'h1111;
        do_redirect("R7", 32'h100);
        chk("R7", "redirect_quiet", 128'(o_fv | o_rq), 128'h0);
        chk("R7", "redirect_pc", 128'(pc_out), 128'h100);
        do_fetch("R3", 2);
        // Dispatch keyed on the PC.
        do_disp("R4", 0, 32'h0, 32'h2340);
        do_fetch("R4", 1);
        chk("R4", "keyed_key", 128'(o_key), 128'({32'h104, 32'h2340}));
        chk("R4", "keyed_flag", 128'(o_keyed), 128'h1);
        do_fetch("R6", 4);
        chk("R6", "pc_frozen", 128'(pc_out), 128'h104);
        chk("R6", "last_word", 128'(o_instr), 128'(line_for({32'h104, 32'h2340})) >> 96);
        do_fetch("R8", 1);
        chk("R8", "overrun", 128'(o_over), 128'h1);
        chk("R8", "overrun_no_issue", 128'(o_fv), 128'h0);
        do_fetch("R8", 1);
        chk("R8", "back_to_pc", 128'(o_keyed), 128'h0);
        // Shared entry through an explicit site value.
        do_redirect("R7", 32'h200);
        do_disp("R5", 1, 32'h5550, 32'hC0DE0);
        do_fetch("R5", 3);
        do_redirect("R7", 32'h300);
        chk("R7", "mid_line_exit", 128'(refill_keyed), 128'h0);
        do_disp("R5", 1, 32'h5550, 32'hC0DE0);
        do_fetch("R5", 1);
        chk("R5", "shared_hit", 128'(o_fv), 128'h1);
        chk("R5", "shared_no_refill", 128'(o_rq), 128'h0);
        // Same key value, different mode: must miss.
        do_redirect("R10", 32'h640);
        do_fetch("R10", 2);
        do_disp("R10", 1, 32'h0, 32'h640);
        do_fetch("R10", 1);
        chk("R10", "mode_alias_miss", 128'(o_rq), 128'h1);
        chk("R10", "alias_key", 128'(o_key), 128'({32'h0, 32'h640}));
        do_fetch("R10", 1);
        // Set 0 conflict.
        do_redirect("R11", 32'h400);
        do_fetch("R11", 2);
        do_redirect("R11", 32'h0);
        do_fetch("R11", 1);
        chk("R11", "evicted_miss", 128'(o_rq), 128'h1);
        do_redirect("R2", 32'h8);
        do_fetch("R2", 1);
        chk("R2", "word_select", 128'(o_instr), 128'(line_for(64'h0)) >> 64 & 128'hFFFF_FFFF);
        finish_run();
    end
endmodule